// File: doc/BRIEF.md
# ACPI Sleep-State Power-Plane Sequencer

This block chooses, for every ACPI system state, which pass elements of three supply planes are switched on. The planes are a 3.3 V dual plane, a 5 V dual plane and a memory rail. Each plane has an active-path switch fed from the main supply and a sleep-path element fed from standby. Two active-low sleep requests select the target state. Two straps decide whether the 3.3 V and 5 V dual planes stay powered while asleep. The straps are captured only at well-defined moments.

All inputs are asynchronous. Each passes through a synchronizer, and the suspend request is also deglitched. A state controller applies the decoded request after a programmable delay. It refuses the active state while the 12 V supply is not reported good, and on a wake from deep sleep it also waits for soft-start completion. Standby power-on reset and external shutdown force every element off. Each rail driver adds a one-cycle break-before-make gap when it hands over between paths. The memory voltage select input is captured once per power-on.

Top module: `pwrplane_seq`

## Requirements
- R1: The synchronized requests {req_deep_n, req_susp_n} decode as follows: 11 gives active, 10 gives suspend and 00 gives deep sleep. plane_state reports 0 for off, 1 for deep sleep, 2 for suspend and 3 for active.
- R2: The request code 01 is illegal. While it is present, the current state is kept.
- R3: The 3.3 V plane uses its active switch in active and its sleep element in suspend. In deep sleep it uses its sleep element only if its latched strap is 1.
- R4: The 5 V plane uses its active switch in active. In suspend and in deep sleep it uses its sleep element only if its latched strap is 1. No sleep element of any rail is on in active.
- R5: The memory rail uses its active driver in active and its sleep element in suspend. In deep sleep both are off.
- R6: While reset is asserted or stby_por_ok is low, the state is off and all enables are 0. After power-on release the state enters deep sleep.
- R7: The straps are captured on every entry into suspend or deep sleep, on power-on release and on shutdown release. Strap changes at any other time do not affect the outputs.
- R8: A change to active is refused while v12_ok is low. A change from deep sleep to active is also refused while ss_done is low.
- R9: A state change takes effect only after the request has been steady for SW_DLY cycles, or WAKE_DLY cycles for deep sleep to active. Before that, the old state is still reported.
- R10: A suspend request pulse shorter than DGL_LEN cycles has no effect.
- R11: mem_hi_lat captures mem_hi_sel the first time ss_done is seen high after power-on release. It then holds that value until the next power-on reset.
- R12: While shdn_req is high, the state is off and all enables are 0. After release the state enters deep sleep.
- R13: The active and sleep enables of a rail are never on together. Neither rises in the cycle directly after the other was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_susp_n | input | 1 | Active-low suspend request (asynchronous) |
| req_deep_n | input | 1 | Active-low deep-sleep request (asynchronous) |
| keep_3v3_strap | input | 1 | Keep the 3.3 V plane powered in deep sleep |
| keep_5v_strap | input | 1 | Keep the 5 V plane powered in sleep states |
| stby_por_ok | input | 1 | Standby supply out of power-on reset |
| v12_ok | input | 1 | 12 V supply good |
| ss_done | input | 1 | Soft-start ramp complete |
| shdn_req | input | 1 | External shutdown |
| mem_hi_sel | input | 1 | Memory voltage select level (1 = high setting) |
| d33_act_en | output | 1 | 3.3 V plane active switch enable |
| d33_slp_en | output | 1 | 3.3 V plane sleep element enable |
| d5_act_en | output | 1 | 5 V plane active switch enable |
| d5_slp_en | output | 1 | 5 V plane sleep element enable |
| mem_act_en | output | 1 | Memory rail active driver enable |
| mem_slp_en | output | 1 | Memory rail sleep element enable |
| mem_hi_lat | output | 1 | Latched memory voltage select |
| plane_state | output | 2 | Current state: 0 off, 1 deep, 2 suspend, 3 active |

## Verification
The vector walk moves through every request code with both strap values. It separates a strap that is captured on entry into sleep from one that changes while asleep and must be ignored. It also separates the illegal code, which holds the state, from a low 12 V or soft-start flag, which blocks only a change to active. Directed patterns set a short suspend pulse against a held one, and sample at a point before the configured delay and at one well after it. They also toggle the straps during shutdown and power-on to show capture at release. A per-cycle monitor watches every handover for overlap and for the break-before-make gap.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [1:0] {
      PS_OFF  = 2'd0,
      PS_DEEP = 2'd1,
      PS_SUSP = 2'd2,
      PS_ACT  = 2'd3
   } pps_state_e;

   localparam int unsigned RAIL_CNT = 3;
   localparam int unsigned RAIL_3V3 = 0;
   localparam int unsigned RAIL_5V  = 1;
   localparam int unsigned RAIL_MEM = 2;

   typedef struct packed {
      logic       valid;
      pps_state_e st;
   } pps_req_t;

   // R1/R2: request decode; code 01 is flagged invalid
   function automatic pps_req_t pps_decode(input logic deep_n, input logic susp_n);
      pps_req_t r;
      r.valid = 1'b1;
      unique case ({deep_n, susp_n})
         2'b11:   r.st = PS_ACT;
         2'b10:   r.st = PS_SUSP;
         2'b00:   r.st = PS_DEEP;
         default: begin
            r.valid = 1'b0;
            r.st    = PS_OFF;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pps_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pps_deglitch.sv
module pps_deglitch #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned CW = $clog2(LEN + 1);

   if (LEN < 2) begin : g_bad_len
      $error("pps_deglitch: LEN must be at least 2");
   end

   logic [CW-1:0] run_q;
   logic          filt_q;

   // R10: the output follows only after LEN consecutive differing cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         filt_q <= 1'b0;
      end else if (d_i == filt_q) begin
         run_q <= '0;
      end else if (run_q == CW'(LEN - 1)) begin
         filt_q <= d_i;
         run_q  <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign q_o = filt_q;
endmodule

// File: rtl/pps_state_ctrl.sv
module pps_state_ctrl
   import pps_pkg::*;
#(
   parameter int unsigned SW_DLY   = 2000,
   parameter int unsigned WAKE_DLY = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_ok,
   input  logic       shdn,
   input  logic       v12_ok,
   input  logic       ss_done,
   input  logic       deep_n,
   input  logic       susp_n,
   input  logic       strap3,
   input  logic       strap5,
   input  logic       msel,
   output pps_state_e state_o,
   output logic       keep3_o,
   output logic       keep5_o,
   output logic       vsel_o
);
   localparam int unsigned MAXD = (SW_DLY > WAKE_DLY) ? SW_DLY : WAKE_DLY;
   localparam int unsigned DW   = $clog2(MAXD + 1);

   if (SW_DLY < 1 || WAKE_DLY < 1) begin : g_bad_dly
      $error("pps_state_ctrl: delays must be at least 1");
   end

   pps_req_t      req;
   pps_state_e    st_q, tgt_q;
   logic [DW-1:0] dly_q, lim;
   logic          go;
   logic          keep3_q, keep5_q, lock_q, vsel_q;

   assign req = pps_decode(deep_n, susp_n);

   // R2, R8: decide whether a change is being requested and allowed
   always_comb begin
      go = req.valid && (req.st != st_q) && (st_q != PS_OFF);
      if (req.st == PS_ACT && !v12_ok) go = 1'b0;
      if (req.st == PS_ACT && st_q == PS_DEEP && !ss_done) go = 1'b0;
      lim = (st_q == PS_DEEP && req.st == PS_ACT) ? DW'(WAKE_DLY - 1) : DW'(SW_DLY - 1);
   end

   // R6, R7, R9, R12: state register with qualifying delay and strap capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_OFF;
         tgt_q   <= PS_OFF;
         dly_q   <= '0;
         keep3_q <= 1'b0;
         keep5_q <= 1'b0;
      end else if (!por_ok || shdn) begin
         st_q  <= PS_OFF;
         dly_q <= '0;
      end else if (st_q == PS_OFF) begin
         st_q    <= PS_DEEP;
         dly_q   <= '0;
         keep3_q <= strap3;
         keep5_q <= strap5;
      end else if (!go) begin
         dly_q <= '0;
      end else if (req.st != tgt_q) begin
         tgt_q <= req.st;
         dly_q <= '0;
      end else if (dly_q >= lim) begin
         st_q  <= req.st;
         dly_q <= '0;
         if (req.st != PS_ACT) begin
            keep3_q <= strap3;
            keep5_q <= strap5;
         end
      end else begin
         dly_q <= dly_q + 1'b1;
      end
   end

   // R11: memory voltage select captured once per power-on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         vsel_q <= 1'b0;
      end else if (!por_ok) begin
         lock_q <= 1'b0;
      end else if (!lock_q && ss_done) begin
         lock_q <= 1'b1;
         vsel_q <= msel;
      end
   end

   assign state_o = st_q;
   assign keep3_o = keep3_q;
   assign keep5_o = keep5_q;
   assign vsel_o  = vsel_q;
endmodule

// File: rtl/pps_rail_bbm.sv
module pps_rail_bbm (
   input  logic clk,
   input  logic rst_n,
   input  logic want_act,
   input  logic want_slp,
   output logic act_en,
   output logic slp_en
);
   logic act_q, slp_q;

   // R13: each path turns on only once the other path was off in the previous cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         slp_q <= 1'b0;
      end else begin
         act_q <= want_act & ~slp_q;
         slp_q <= want_slp & ~act_q & ~want_act;
      end
   end

   assign act_en = act_q;
   assign slp_en = slp_q;
endmodule

// File: rtl/pwrplane_seq.sv
module pwrplane_seq
   import pps_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DGL_LEN     = 16,
   parameter int unsigned SW_DLY      = 2000,
   parameter int unsigned WAKE_DLY    = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_susp_n,
   input  logic       req_deep_n,
   input  logic       keep_3v3_strap,
   input  logic       keep_5v_strap,
   input  logic       stby_por_ok,
   input  logic       v12_ok,
   input  logic       ss_done,
   input  logic       shdn_req,
   input  logic       mem_hi_sel,
   output logic       d33_act_en,
   output logic       d33_slp_en,
   output logic       d5_act_en,
   output logic       d5_slp_en,
   output logic       mem_act_en,
   output logic       mem_slp_en,
   output logic       mem_hi_lat,
   output logic [1:0] plane_state
);
   localparam int unsigned NIN = 9;

   logic [NIN-1:0] raw_in, syn_in;
   logic           susp_filt;
   pps_state_e     st;
   logic           keep3, keep5;
   logic [RAIL_CNT-1:0] want_act, want_slp, act_en, slp_en;

   assign raw_in = {mem_hi_sel, shdn_req, ss_done, v12_ok, stby_por_ok,
                    keep_5v_strap, keep_3v3_strap, req_deep_n, req_susp_n};

   pps_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
   );

   pps_deglitch #(.LEN(DGL_LEN)) u_dgl (
      .clk(clk), .rst_n(rst_n), .d_i(syn_in[0]), .q_o(susp_filt)
   );

   pps_state_ctrl #(.SW_DLY(SW_DLY), .WAKE_DLY(WAKE_DLY)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .por_ok(syn_in[4]), .shdn(syn_in[7]), .v12_ok(syn_in[5]), .ss_done(syn_in[6]),
      .deep_n(syn_in[1]), .susp_n(susp_filt),
      .strap3(syn_in[2]), .strap5(syn_in[3]), .msel(syn_in[8]),
      .state_o(st), .keep3_o(keep3), .keep5_o(keep5), .vsel_o(mem_hi_lat)
   );

   // R3, R4, R5: plane map per state
   always_comb begin
      want_act           = {RAIL_CNT{st == PS_ACT}};
      want_slp[RAIL_3V3] = (st == PS_SUSP) || (st == PS_DEEP && keep3);
      want_slp[RAIL_5V]  = (st == PS_SUSP || st == PS_DEEP) && keep5;
      want_slp[RAIL_MEM] = (st == PS_SUSP);
   end

   for (genvar r = 0; r < int'(RAIL_CNT); r++) begin : g_rail
      pps_rail_bbm u_bbm (
         .clk(clk), .rst_n(rst_n),
         .want_act(want_act[r]), .want_slp(want_slp[r]),
         .act_en(act_en[r]), .slp_en(slp_en[r])
      );
   end

   assign d33_act_en  = act_en[RAIL_3V3];
   assign d33_slp_en  = slp_en[RAIL_3V3];
   assign d5_act_en   = act_en[RAIL_5V];
   assign d5_slp_en   = slp_en[RAIL_5V];
   assign mem_act_en  = act_en[RAIL_MEM];
   assign mem_slp_en  = slp_en[RAIL_MEM];
   assign plane_state = st;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] plane_state,
   input logic       d33_act_en,
   input logic       d33_slp_en,
   input logic       d5_act_en,
   input logic       d5_slp_en,
   input logic       mem_act_en,
   input logic       mem_slp_en
);
   p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(d33_act_en && d33_slp_en) && !(d5_act_en && d5_slp_en) && !(mem_act_en && mem_slp_en));

   p_gap_d33_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(d33_slp_en) |-> !$past(d33_act_en)) and ($rose(d33_act_en) |-> !$past(d33_slp_en)));

   p_gap_mem_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_slp_en) |-> !$past(mem_act_en)) and ($rose(mem_act_en) |-> !$past(mem_slp_en)));

   p_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      plane_state == 2'd0 |=> !d33_act_en && !d33_slp_en && !d5_act_en && !d5_slp_en
                              && !mem_act_en && !mem_slp_en);

   p_mem_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      plane_state == 2'd1 |=> !mem_act_en && !mem_slp_en);

   p_act_no_slp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      plane_state == 2'd3 |=> !d33_slp_en && !d5_slp_en && !mem_slp_en);

   p_enter_deep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_state != 2'd0 && $past(plane_state) == 2'd0) |-> plane_state == 2'd1);
endmodule

bind pwrplane_seq pps_chk i_chk (
   .clk(clk), .rst_n(rst_n), .plane_state(plane_state),
   .d33_act_en(d33_act_en), .d33_slp_en(d33_slp_en),
   .d5_act_en(d5_act_en), .d5_slp_en(d5_slp_en),
   .mem_act_en(mem_act_en), .mem_slp_en(mem_slp_en)
);

// File: tb/test_pwrplane_seq.sv
module test_pwrplane_seq;
   localparam int unsigned DGL = 4;
   localparam int unsigned SWD = 8;
   localparam int unsigned WKD = 20;
   localparam int SETTLE = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_susp_n = 1'b0, req_deep_n = 1'b0;
   logic keep_3v3_strap = 1'b0, keep_5v_strap = 1'b0;
   logic stby_por_ok = 1'b0, v12_ok = 1'b0, ss_done = 1'b0, shdn_req = 1'b0, mem_hi_sel = 1'b0;
   logic d33_act_en, d33_slp_en, d5_act_en, d5_slp_en, mem_act_en, mem_slp_en, mem_hi_lat;
   logic [1:0] plane_state;

   int n_chk = 0;
   int n_bad = 0;
   int n_olap = 0;
   int n_hand = 0;

   always #2.5 clk = ~clk;

   pwrplane_seq #(.SYNC_STAGES(2), .DGL_LEN(DGL), .SW_DLY(SWD), .WAKE_DLY(WKD)) i_pwrplane_seq (
      .clk(clk), .rst_n(rst_n), .req_susp_n(req_susp_n), .req_deep_n(req_deep_n),
      .keep_3v3_strap(keep_3v3_strap), .keep_5v_strap(keep_5v_strap),
      .stby_por_ok(stby_por_ok), .v12_ok(v12_ok), .ss_done(ss_done), .shdn_req(shdn_req),
      .mem_hi_sel(mem_hi_sel), .d33_act_en(d33_act_en), .d33_slp_en(d33_slp_en),
      .d5_act_en(d5_act_en), .d5_slp_en(d5_slp_en), .mem_act_en(mem_act_en),
      .mem_slp_en(mem_slp_en), .mem_hi_lat(mem_hi_lat), .plane_state(plane_state)
   );

   // {deep_n, susp_n, strap3, strap5, v12, ssd} , {state[1:0], a3, p3, a5, p5, am, pm}
   localparam logic [13:0] VEC [14] = '{
      14'b111011_11101010,  // R1 active
      14'b110111_11101010,  // R7 straps change while active
      14'b100111_10010101,  // R1 suspend, R7 capture on entry
      14'b001011_01010000,  // R3 deep with 3.3 V kept, R7 capture
      14'b000111_01010000,  // R7 straps ignored in deep
      14'b010111_01010000,  // R2 illegal code holds deep
      14'b110101_01010000,  // R8 no 12 V
      14'b110110_01010000,  // R8 no soft-start from deep
      14'b110111_11101010,  // R8 allowed wake
      14'b010111_11101010,  // R2 illegal code holds active
      14'b100011_10010001,  // R5 suspend memory on sleep path
      14'b110001_10010001,  // R8 no 12 V from suspend
      14'b110010_11101010,  // R8 suspend to active ignores soft-start
      14'b000011_01000000   // R4 R5 deep all off
   };

   function automatic logic [7:0] outs();
      return {plane_state, d33_act_en, d33_slp_en, d5_act_en, d5_slp_en, mem_act_en, mem_slp_en};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // R13 monitor: overlap and handover gap
   logic pa3 = 1'b0, pa3b = 1'b0;
   always @(negedge clk) begin
      if ((d33_act_en && d33_slp_en) || (d5_act_en && d5_slp_en) || (mem_act_en && mem_slp_en))
         n_olap++;
      if (d33_slp_en && !pa3 && pa3b) n_hand++;
      if (d33_slp_en && pa3) n_olap++;
      pa3b <= pa3;
      pa3  <= d33_act_en;
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      // R6 reset state
      wait_n(3);
      chk("R6 reset", outs(), 8'b0);
      chk("R11 reset vsel", {7'b0, mem_hi_lat}, 8'b0);
      rst_n = 1'b1;
      wait_n(10);
      chk("R6 por held", outs(), 8'b0);
      keep_3v3_strap = 1'b1; keep_5v_strap = 1'b0; v12_ok = 1'b1; mem_hi_sel = 1'b1;
      stby_por_ok = 1'b1;
      wait_n(SETTLE);
      chk("R6 deep after por", outs(), 8'b01010000);
      chk("R11 no latch before ssd", {7'b0, mem_hi_lat}, 8'b0);
      ss_done = 1'b1;
      wait_n(10);
      chk("R11 latch", {7'b0, mem_hi_lat}, 8'b1);
      mem_hi_sel = 1'b0;
      wait_n(10);
      chk("R11 hold", {7'b0, mem_hi_lat}, 8'b1);

      for (int i = 0; i < 14; i++) begin
         {req_deep_n, req_susp_n, keep_3v3_strap, keep_5v_strap, v12_ok, ss_done} = VEC[i][13:8];
         wait_n(SETTLE);
         chk($sformatf("vector %0d (R1 R2 R3 R4 R5 R7 R8)", i), outs(), VEC[i][7:0]);
      end

      // R10 short suspend pulse ignored
      req_deep_n = 1'b1; req_susp_n = 1'b1; v12_ok = 1'b1; ss_done = 1'b1;
      wait_n(SETTLE);
      chk("R1 active again", outs(), 8'b11101010);
      req_susp_n = 1'b0;
      wait_n(2);
      req_susp_n = 1'b1;
      wait_n(SETTLE);
      chk("R10 glitch", outs(), 8'b11101010);

      // R9 switch delay
      req_susp_n = 1'b0;
      wait_n(int'(SWD));
      chk("R9 early", {6'b0, plane_state}, 8'd3);
      wait_n(SETTLE);
      chk("R9 late", {6'b0, plane_state}, 8'd2);

      // R9 wake delay
      req_deep_n = 1'b0;
      wait_n(SETTLE);
      chk("R1 deep", {6'b0, plane_state}, 8'd1);
      req_deep_n = 1'b1; req_susp_n = 1'b1;
      wait_n(int'(WKD));
      chk("R9 wake early", {6'b0, plane_state}, 8'd1);
      wait_n(SETTLE);
      chk("R9 wake late", {6'b0, plane_state}, 8'd3);

      // R12 shutdown
      keep_3v3_strap = 1'b1; keep_5v_strap = 1'b1;
      shdn_req = 1'b1;
      wait_n(10);
      chk("R12 shutdown off", outs(), 8'b0);
      keep_3v3_strap = 1'b0; keep_5v_strap = 1'b1;
      req_deep_n = 1'b0; req_susp_n = 1'b0;
      wait_n(5);
      shdn_req = 1'b0;
      wait_n(SETTLE);
      chk("R12 R7 deep after shutdown", outs(), 8'b01000100);

      // R6 power-on again, R11 relatch
      stby_por_ok = 1'b0;
      wait_n(10);
      chk("R6 por drop", outs(), 8'b0);
      keep_3v3_strap = 1'b1; keep_5v_strap = 1'b0;
      stby_por_ok = 1'b1;
      wait_n(SETTLE);
      chk("R6 R7 deep after por", outs(), 8'b01010000);
      chk("R11 relatch", {7'b0, mem_hi_lat}, 8'b0);
      mem_hi_sel = 1'b1; ss_done = 1'b0;
      wait_n(5);
      ss_done = 1'b1;
      wait_n(10);
      chk("R11 single latch", {7'b0, mem_hi_lat}, 8'b0);

      // R13 summary of monitor
      chk("R13 overlap", n_olap[7:0], 8'd0);
      chk("R13 handover seen", {7'b0, (n_hand > 0)}, 8'd1);
      summary();
   end
endmodule